// File: doc/BRIEF.md
# Sequential Dot-Product Accumulator

This unit computes a signed dot product over a short vector, one element at a time. One operand stream comes from a bank of 32-bit registers, each register holding two 16-bit elements. The other operand stream comes from memory as 16-bit words. A start request carries three values: a control word that gives the element count and the memory layout, a byte pointer to the matrix data, and the index of the first register. Once accepted, the unit issues one word-read request at a time. Each time a read is acknowledged it multiplies one register element by the returned word and adds the product to a signed 32-bit total.

When the last element is consumed, the unit publishes the total together with zero and negative flags and raises a one-cycle done pulse. It can step through memory in two ways. In row layout, consecutive elements sit four bytes apart. In column layout, the step is four bytes times the element count, so the same unit can walk down a column of a matrix stored row by row.

The memory system and the register file are outside the block. The register read port is combinational: the index goes out and the data comes back in the same cycle.

Top module: `mm_dot_unit`

## Requirements
- R1: A synchronous active-low reset leaves the unit idle. After reset, busy, done and the memory request are low, the result is 0, and both flags are 0.
- R2: The element count is control bits [3:0], and control bit 4 selects the layout (0 = row, 1 = column). An operation consumes exactly that many acknowledged reads.
- R3: Element i is read from register (base + (i >> 1)) mod 32. An even i uses bits [31:16] of that register and an odd i uses bits [15:0].
- R4: The read address for the current element is the element pointer plus 2, and the pointer starts at the start pointer. The address and register index hold steady while a request waits for its acknowledge.
- R5: After each acknowledged element the pointer advances by 4 in row layout or by 4 × count in column layout, modulo 2^24.
- R6: Each element pair is multiplied as two signed 16-bit values. The products are summed into an accumulator that starts at zero and wraps modulo 2^32.
- R7: For a nonzero count, busy and the memory request rise in the cycle after the accepted start. Done is high for one cycle, in the cycle after the acknowledge of the last element, and busy is low in that same cycle.
- R8: Result, negative (result bit 31) and zero (result equal to 0) are updated together with done and hold until the next done.
- R9: A count of 0 makes no memory request. It raises done in the cycle after the start, with result 0, zero = 1 and negative = 0.
- R10: A start request that arrives while busy is ignored, and the running operation completes with its own operands.
- R11: An acknowledge that arrives while no request is pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled only while idle |
| ctrl_i | input | 5 | [3:0] element count, [4] layout (1 = column) |
| ptr_i | input | 24 | Byte pointer to the first matrix element |
| base_i | input | 5 | First register index |
| mem_req_o | output | 1 | Word-read request |
| mem_addr_o | output | 24 | Word-read byte address |
| mem_ack_i | input | 1 | Read acknowledge, data valid this cycle |
| mem_rdata_i | input | 16 | Read data |
| rf_idx_o | output | 5 | Register read index |
| rf_data_i | input | 32 | Register read data (same cycle) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Signed dot product |
| flag_z_o | output | 1 | Result is zero |
| flag_n_o | output | 1 | Result is negative |

## Verification
Busy and the first request are due one cycle after a start is sampled. A count-0 start produces its done, zero result and zero flag one cycle later. Each acknowledge moves the address, the register index and the accumulator at the next edge. The last acknowledge brings done, the result and the flags one edge later. The bench keeps a behavioural model that advances on the same rising edge as the design and compares every output at the following falling edge, so each expectation is sampled exactly one register delay after its cause. Per-operation checks then compare the result against a dot product computed from scratch, and they count the acknowledged reads.

// File: rtl/mm_pkg.sv
// Package: shared constants, types and helpers for the dot-product unit.
// Assumes byte addressing with 16-bit memory elements, two per register.
package mm_pkg;

    // Memory walk order selected by the top control bit.
    typedef enum logic {
        LAYOUT_ROW = 1'b0,
        LAYOUT_COL = 1'b1
    } layout_e;

    // Byte offset from the element pointer to the word actually read.
    localparam int unsigned ELEM_OFS   = 2;
    // Byte step between elements in row layout.
    localparam int unsigned ROW_STEP   = 4;
    // Shift that turns an element count into a column step (x4).
    localparam int unsigned COL_SHIFT  = 2;

    // Pick the 16-bit element inside a packed register: even = upper half.
    function automatic logic [15:0] pick_half(input logic [31:0] word,
                                              input logic odd);
        return odd ? word[15:0] : word[31:16];
    endfunction

endpackage

// File: rtl/mm_seq.sv
// Module: mm_seq
// Sequencer for one dot-product operation. It accepts a start while idle,
// latches count, layout and base, counts acknowledged elements and
// produces the step, finish and empty strobes that the datapath consumes.
// Assumes ack_i is meaningful only while a request is outstanding.
module mm_seq
    import mm_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  layout_e           mode_i,
    input  logic [RIDX_W-1:0] base_i,
    input  logic              ack_i,
    output logic              accept_o,
    output logic              step_o,
    output logic              fin_o,
    output logic              empty_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  idx_o,
    output logic [CNT_W-1:0]  cnt_o,
    output layout_e           mode_o,
    output logic [RIDX_W-1:0] base_o
);

    logic              busy_q;
    logic              done_q;
    logic [CNT_W-1:0]  idx_q;
    logic [CNT_W-1:0]  cnt_q;
    layout_e           mode_q;
    logic [RIDX_W-1:0] base_q;
    logic              last_elem;

    // Decode the per-cycle strobes from the current state and inputs.
    always_comb begin
        accept_o  = start_i && !busy_q;
        step_o    = busy_q && ack_i;
        last_elem = (idx_q == (cnt_q - CNT_W'(1)));
        fin_o     = step_o && last_elem;
        empty_o   = accept_o && (cnt_i == '0);
    end

    // Busy/done control and element counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            idx_q  <= '0;
        end else begin
            done_q <= fin_o || empty_o;
            if (accept_o) begin
                busy_q <= (cnt_i != '0);
                idx_q  <= '0;
            end else if (step_o) begin
                idx_q <= idx_q + CNT_W'(1);
                if (last_elem) begin
                    busy_q <= 1'b0;
                end
            end
        end
    end

    // Operand capture, only when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            mode_q <= LAYOUT_ROW;
            base_q <= '0;
        end else if (accept_o) begin
            cnt_q  <= cnt_i;
            mode_q <= mode_i;
            base_q <= base_i;
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign idx_o  = idx_q;
    assign cnt_o  = cnt_q;
    assign mode_o = mode_q;
    assign base_o = base_q;

    // R7: a nonzero-count start makes the unit busy on the next cycle.
    p_busy_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && cnt_i != '0) |=> busy_q);

    // R7: the done pulse never coincides with busy.
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);

    // R10: latched operands stay put while an operation runs.
    p_ignore_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> ($stable(cnt_q) && $stable(base_q) && $stable(mode_q)));

    // R2: the element index never reaches the latched count while busy.
    p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (idx_q < cnt_q));

endmodule

// File: rtl/mm_addr.sv
// Module: mm_addr
// Element pointer for the memory stream. It loads the start pointer,
// fixes the per-element step from layout and count at load time, and
// advances once per acknowledged element. The read address is pointer + 2.
// Assumes load_i and step_i are never high together.
module mm_addr
    import mm_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic              busy_i,
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  layout_e           mode_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] stride_q;
    logic [ADDR_W-1:0] stride_d;

    // Per-element step chosen by the layout.
    always_comb begin
        if (mode_i == LAYOUT_COL) begin
            stride_d = ADDR_W'(cnt_i) << COL_SHIFT;
        end else begin
            stride_d = ADDR_W'(ROW_STEP);
        end
    end

    // Pointer and step registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            stride_q <= '0;
        end else if (load_i) begin
            ptr_q    <= ptr_i;
            stride_q <= stride_d;
        end else if (step_i) begin
            ptr_q <= ptr_q + stride_q;
        end
    end

    assign addr_o = ptr_q + ADDR_W'(ELEM_OFS);

    // R5: each consumed element moves the pointer by exactly one step.
    p_stride_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (ptr_q == $past(ptr_q) + $past(stride_q)));

    // R4: the pointer is held while a request waits for its acknowledge.
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !step_i) |=> $stable(ptr_q));

endmodule

// File: rtl/mm_acc.sv
// Module: mm_acc
// Multiply-accumulate datapath. It selects the register half for the
// current element, forms a signed 16x16 product with the memory word and
// adds it to a 32-bit accumulator. On finish it publishes the total and
// its flags; an empty operation publishes zero.
// Assumes clear_i and step_i are never high together.
module mm_acc
    import mm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              step_i,
    input  logic              fin_i,
    input  logic              empty_i,
    input  logic              odd_i,
    input  logic [DATA_W-1:0] rf_data_i,
    input  logic [HALF_W-1:0] mem_data_i,
    output logic [DATA_W-1:0] result_o,
    output logic              flag_z_o,
    output logic              flag_n_o
);

    logic signed [HALF_W-1:0] reg_elem;
    logic signed [HALF_W-1:0] mem_elem;
    logic signed [DATA_W-1:0] prod;
    logic        [DATA_W-1:0] sum;
    logic        [DATA_W-1:0] acc_q;
    logic        [DATA_W-1:0] result_q;
    logic                     z_q;
    logic                     n_q;

    // Operand selection, signed product and running sum.
    always_comb begin
        reg_elem = pick_half(rf_data_i, odd_i);
        mem_elem = mem_data_i;
        prod     = DATA_W'(reg_elem) * DATA_W'(mem_elem);
        sum      = acc_q + prod;
    end

    // Running accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear_i) begin
            acc_q <= '0;
        end else if (step_i) begin
            acc_q <= sum;
        end
    end

    // Published result and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            z_q      <= 1'b0;
            n_q      <= 1'b0;
        end else if (empty_i) begin
            result_q <= '0;
            z_q      <= 1'b1;
            n_q      <= 1'b0;
        end else if (fin_i) begin
            result_q <= sum;
            z_q      <= (sum == '0);
            n_q      <= sum[DATA_W-1];
        end
    end

    assign result_o = result_q;
    assign flag_z_o = z_q;
    assign flag_n_o = n_q;

    // R6: a new operation starts from a zero total.
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (acc_q == '0));

    // R6: each non-final element adds exactly its product.
    p_accum_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !fin_i) |=> (acc_q == $past(acc_q) + $past(prod)));

    // R8: the result and flags hold between completions.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fin_i || empty_i) |=> ($stable(result_q) && $stable(z_q) && $stable(n_q)));

    // R9: an empty operation reports zero with the zero flag set.
    p_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        empty_i |=> (result_q == '0 && z_q && !n_q));

endmodule

// File: rtl/mm_dot_unit.sv
// Module: mm_dot_unit (top)
// Sequential dot product of packed register elements with 16-bit memory
// words. It ties the sequencer, the pointer and the accumulator together
// and forms the register index base + (element >> 1).
// Assumes a combinational register read port and a memory port that
// returns data in the cycle it acknowledges.
module mm_dot_unit
    import mm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 4,
    parameter int RIDX_W = 5,
    localparam int HALF_W = DATA_W / 2,
    localparam int CTRL_W = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic [RIDX_W-1:0] base_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_ack_i,
    input  logic [HALF_W-1:0] mem_rdata_i,
    output logic [RIDX_W-1:0] rf_idx_o,
    input  logic [DATA_W-1:0] rf_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] result_o,
    output logic              flag_z_o,
    output logic              flag_n_o
);

    logic              accept;
    logic              step;
    logic              fin;
    logic              empty;
    logic              busy;
    logic [CNT_W-1:0]  idx;
    logic [CNT_W-1:0]  cnt_q;
    layout_e           mode_q;
    logic [RIDX_W-1:0] base_q;
    layout_e           mode_in;

    assign mode_in = layout_e'(ctrl_i[CNT_W]);

    mm_seq #(.CNT_W(CNT_W), .RIDX_W(RIDX_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .cnt_i    (ctrl_i[CNT_W-1:0]),
        .mode_i   (mode_in),
        .base_i   (base_i),
        .ack_i    (mem_ack_i),
        .accept_o (accept),
        .step_o   (step),
        .fin_o    (fin),
        .empty_o  (empty),
        .busy_o   (busy),
        .done_o   (done_o),
        .idx_o    (idx),
        .cnt_o    (cnt_q),
        .mode_o   (mode_q),
        .base_o   (base_q)
    );

    mm_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .step_i (step),
        .busy_i (busy),
        .ptr_i  (ptr_i),
        .cnt_i  (ctrl_i[CNT_W-1:0]),
        .mode_i (mode_in),
        .addr_o (mem_addr_o)
    );

    mm_acc #(.DATA_W(DATA_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (accept),
        .step_i     (step),
        .fin_i      (fin),
        .empty_i    (empty),
        .odd_i      (idx[0]),
        .rf_data_i  (rf_data_i),
        .mem_data_i (mem_rdata_i),
        .result_o   (result_o),
        .flag_z_o   (flag_z_o),
        .flag_n_o   (flag_n_o)
    );

    // Register index for the current element: two elements per register.
    always_comb begin
        rf_idx_o = base_q + RIDX_W'(idx >> 1);
    end

    assign mem_req_o = busy;
    assign busy_o    = busy;

    // R3: the register index moves only when an element is consumed or a start loads.
    p_idx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step) |=> $stable(rf_idx_o));

    // R9: an empty operation never raises a request.
    p_no_req_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        empty |=> !mem_req_o);

    // R11: with no request pending, an acknowledge leaves the running total alone.
    p_stray_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !accept) |=> $stable(result_o));

endmodule

// File: tb/tb_mm_dot_unit.sv
// Bench: behavioural per-cycle model of the dot-product unit compared on
// every falling edge, plus per-operation checks against a dot product
// computed from scratch.
module tb_mm_dot_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [4:0]  ctrl_i = '0;
    logic [23:0] ptr_i = '0;
    logic [4:0]  base_i = '0;
    logic        mem_req_o;
    logic [23:0] mem_addr_o;
    logic        mem_ack_i = 1'b0;
    logic [15:0] mem_rdata_i = '0;
    logic [4:0]  rf_idx_o;
    logic [31:0] rf_data_i;
    logic        busy_o, done_o, flag_z_o, flag_n_o;
    logic [31:0] result_o;

    logic [31:0] regs [32];
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;
    int          acks = 0;
    int          reqs = 0;
    bit          fast = 1'b1;
    bit          stray = 1'b0;
    bit          armed = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    // Model state.
    logic        m_busy = 0, m_done = 0, m_z = 0, m_n = 0, m_col = 0;
    logic [31:0] m_res = 0, m_acc = 0;
    logic [23:0] m_ptr = 0;
    logic [4:0]  m_base = 0;
    int          m_idx = 0, m_cnt = 0;

    always #2 clk = ~clk;

    assign rf_data_i = regs[rf_idx_o];

    mm_dot_unit dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctrl_i(ctrl_i),
        .ptr_i(ptr_i), .base_i(base_i), .mem_req_o(mem_req_o),
        .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
        .mem_rdata_i(mem_rdata_i), .rf_idx_o(rf_idx_o), .rf_data_i(rf_data_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
        .flag_z_o(flag_z_o), .flag_n_o(flag_n_o)
    );

    function automatic logic [15:0] mem_word(input logic [23:0] a);
        logic [23:0] h;
        if (a[23:20] == 4'hA) return 16'h8000;
        h = (a * 24'h00B5A7) ^ (a >> 7);
        return h[15:0] ^ 16'h3C96;
    endfunction

    function automatic logic [15:0] half_of(input logic [31:0] w, input int i);
        return (i % 2 == 0) ? w[31:16] : w[15:0];
    endfunction

    function automatic logic [31:0] dot_ref(input logic [4:0] ctrl,
                                            input logic [23:0] ptr,
                                            input logic [4:0] base);
        logic [31:0] acc = 0;
        int n = int'(ctrl[3:0]);
        logic [23:0] step = ctrl[4] ? 24'(n * 4) : 24'd4;
        for (int i = 0; i < n; i++) begin
            logic [4:0]  ri = 5'(int'(base) + i / 2);
            logic [23:0] ad = ptr + 24'(i) * step + 24'd2;
            logic signed [15:0] a = half_of(regs[ri], i);
            logic signed [15:0] b = mem_word(ad);
            acc = acc + 32'($signed(32'(a)) * $signed(32'(b)));
        end
        return acc;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Reference model: advances on the same edge as the design.
    always @(posedge clk) begin
        logic signed [15:0] a, b;
        logic [31:0] s;
        cyc++;
        if (!rst_n) begin
            m_busy <= 0; m_done <= 0; m_res <= 0; m_z <= 0; m_n <= 0;
            m_acc <= 0; m_idx <= 0; m_ptr <= 0;
        end else begin
            if (mem_ack_i && mem_req_o) acks++;
            if (mem_req_o) reqs++;
            m_done <= 0;
            if (start_i && !m_busy) begin
                m_cnt <= int'(ctrl_i[3:0]); m_col <= ctrl_i[4]; m_base <= base_i;
                m_ptr <= ptr_i; m_acc <= 0; m_idx <= 0;
                if (ctrl_i[3:0] == 0) begin
                    m_done <= 1; m_res <= 0; m_z <= 1; m_n <= 0;
                end else m_busy <= 1;
            end else if (m_busy && mem_ack_i) begin
                a = half_of(regs[5'(int'(m_base) + m_idx / 2)], m_idx);
                b = mem_word(m_ptr + 24'd2);
                s = m_acc + 32'($signed(32'(a)) * $signed(32'(b)));
                m_acc <= s;
                m_ptr <= m_ptr + (m_col ? 24'(m_cnt * 4) : 24'd4);
                m_idx <= m_idx + 1;
                if (m_idx == m_cnt - 1) begin
                    m_busy <= 0; m_done <= 1; m_res <= s;
                    m_z <= (s == 0); m_n <= s[31];
                end
            end
        end
    end

    // Per-cycle compare, then drive the memory responder.
    always @(negedge clk) begin
        if (armed) begin
            check(busy_o == m_busy, "R7 busy", 32'(busy_o), 32'(m_busy));
            check(mem_req_o == m_busy, "R7 request", 32'(mem_req_o), 32'(m_busy));
            check(done_o == m_done, "R7 done", 32'(done_o), 32'(m_done));
            check(result_o == m_res, "R8 result", result_o, m_res);
            check(flag_z_o == m_z, "R8 zero flag", 32'(flag_z_o), 32'(m_z));
            check(flag_n_o == m_n, "R8 negative flag", 32'(flag_n_o), 32'(m_n));
            if (m_busy) begin
                check(mem_addr_o == m_ptr + 24'd2, "R4 R5 address",
                      32'(mem_addr_o), 32'(m_ptr + 24'd2));
                check(rf_idx_o == 5'(int'(m_base) + m_idx / 2), "R3 register index",
                      32'(rf_idx_o), 32'(5'(int'(m_base) + m_idx / 2)));
            end
        end
        mem_ack_i   <= (mem_req_o && (fast || lfsr[0])) || (stray && !mem_req_o && lfsr[1]);
        mem_rdata_i <= mem_req_o ? mem_word(mem_addr_o) : lfsr;
        lfsr        <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic run_op(input logic [4:0] ctrl, input logic [23:0] ptr,
                          input logic [4:0] base, input bit poke);
        logic [31:0] exp = dot_ref(ctrl, ptr, base);
        int k = 0;
        @(negedge clk);
        acks = 0; reqs = 0;
        start_i = 1; ctrl_i = ctrl; ptr_i = ptr; base_i = base;
        @(negedge clk);
        while (!done_o && k < 2000) begin
            start_i = poke && (k == 1);
            ctrl_i  = poke ? (ctrl ^ 5'h13) : ctrl;
            base_i  = poke ? base + 5'd3 : base;
            @(negedge clk);
            k++;
        end
        start_i = 0;
        check(done_o == 1'b1, "R7 completion seen", 32'(done_o), 32'd1);
        check(result_o == exp, poke ? "R10 result after ignored start" : "R6 dot product",
              result_o, exp);
        check(flag_z_o == (exp == 0), "R8 zero vs total", 32'(flag_z_o), 32'(exp == 0));
        check(flag_n_o == exp[31], "R8 negative vs total", 32'(flag_n_o), 32'(exp[31]));
        check(acks == int'(ctrl[3:0]), "R2 reads per operation", 32'(acks), 32'(ctrl[3:0]));
        if (ctrl[3:0] == 0)
            check(reqs == 0, "R9 no request for empty", 32'(reqs), 32'd0);
        repeat (3) @(negedge clk);
        check(result_o == exp, "R8 result holds", result_o, exp);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) regs[i] = 32'(i) * 32'h9E3779B1 ^ 32'h1234ABCD;
        for (int i = 4; i < 8; i++) regs[i] = 32'h0;
        regs[8]  = 32'h7FFF7FFF;
        regs[9]  = 32'h80008000;
        regs[10] = 32'h80008000;
        repeat (4) @(negedge clk);
        check(busy_o == 0 && done_o == 0 && mem_req_o == 0, "R1 reset idle",
              {29'd0, busy_o, done_o, mem_req_o}, 32'd0);
        check(result_o == 0 && flag_z_o == 0 && flag_n_o == 0, "R1 reset result",
              result_o, 32'd0);
        rst_n = 1; armed = 1;
        run_op(5'h00, 24'h001000, 5'd3, 0);           // R9 empty
        run_op(5'h01, 24'h000200, 5'd1, 0);           // single element
        run_op(5'h05, 24'h003004, 5'd12, 0);          // R3 odd/even halves
        run_op(5'h0F, 24'h0FFFF0, 5'd20, 0);          // R5 row, address wrap region
        run_op(5'h13, 24'h100000, 5'd2, 0);           // R5 column, 3 elements
        run_op(5'h18, 24'h200040, 5'd16, 0);          // column, 8 elements
        run_op(5'h1F, 24'hFFFF00, 5'd28, 0);          // R3 register wrap, R5 pointer wrap
        run_op(5'h08, 24'h004000, 5'd4, 0);           // zero registers -> zero
        run_op(5'h02, 24'hA00000, 5'd8, 0);           // negative total
        run_op(5'h04, 24'hA00000, 5'd9, 0);           // R6 wrap to zero
        run_op(5'h02, 24'hA00100, 5'd9, 0);           // R6 wrap to 0x80000000
        run_op(5'h06, 24'h005000, 5'd6, 1);           // R10 start while busy
        fast = 0; stray = 1;                          // R11 stray acks, slow memory
        run_op(5'h07, 24'h006000, 5'd11, 0);
        run_op(5'h1A, 24'h007000, 5'd24, 1);
        run_op(5'h00, 24'h008000, 5'd0, 0);
        repeat (20) @(negedge clk);                   // R11 idle with stray acks
        check(result_o == 0 && flag_z_o == 1, "R11 idle ack ignored", result_o, 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule